// File: doc/BRIEF.md
# Hashed Chain Lookup Allocator

This block turns a program-counter key into a handle for a region of a linear element store. The key is hashed to pick one of a power-of-two number of chains. Each chain holds a fixed number of slots, and each slot stores a key and a handle. The selected chain is walked slot by slot. A matching key returns the handle that was stored with it.

On a miss, the block picks a slot, carves the requested number of elements off a bump pointer, and stores the key and the start handle in that slot. If the chain holds no free slot, the victim is the slot at the position of one rotating counter that all chains share. If the store does not have enough room left for the request, the whole store and every chain are emptied first, and the allocation then starts from handle zero.

A client presents one request at a time while `req_ready` is high. It then waits for the one-cycle `rsp_valid` pulse. Hit, miss and full-flush event pulses arrive in the same cycle as the response. A flush input empties the table and the store between requests.

Top module: `pc_chain_alloc`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and all event outputs are 0, every slot is empty, the bump pointer is 0 and the rotating counter is 0.
- R2: The chain index is `(key ^ (key >> 2)) & (NCHAIN-1)`. The key value with every bit set marks an empty slot and is never presented as a request key.
- R3: The chain is walked from slot 0 upward, one slot per clock. Counted in clock edges after the accepting edge, `rsp_valid` rises after i+1 edges for a hit at slot i, after i+2 edges for an empty slot found at slot i, and after CHAIN_LEN+1 edges when every slot is occupied by other keys.
- R4: On a hit, `rsp_hit` is 1, `rsp_handle` is the handle stored in that slot, and `hit_evt` pulses with `rsp_valid`. The table and the bump pointer are left unchanged.
- R5: On a miss, `rsp_hit` is 0 and `miss_evt` pulses with `rsp_valid`. The chosen slot takes the key and the allocated handle, and `rsp_handle` reports that handle.
- R6: A miss that finds no empty slot replaces the slot at the position of the shared rotating counter. The counter then advances by one and wraps to 0 after CHAIN_LEN-1.
- R7: A miss that needs no flush allocates at the current bump pointer and advances the pointer by `req_count`. A `req_count` of 0 is allowed. `req_count` never exceeds STORE_SIZE.
- R8: If STORE_SIZE minus the bump pointer is less than `req_count`, every slot is emptied and the pointer is set to 0 before the allocation. The handle is then 0, the pointer becomes `req_count`, and `flush_evt` pulses together with `miss_evt`.
- R9: A `flush_in` pulse while idle empties every slot and sets the bump pointer to 0. It leaves the rotating counter unchanged and produces no response. It takes priority over `req_valid` in the same cycle: `req_ready` is 0 in that cycle and the request is not taken.
- R10: `req_ready` is 0 from the accepting edge until the response cycle. `rsp_valid` and the event outputs are single-cycle pulses, and events are never high without `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_key | input | KEY_W | Program-counter key |
| req_count | input | P_W | Elements to allocate on a miss |
| req_ready | output | 1 | Idle and able to take a request |
| flush_in | input | 1 | Empty the table and the store |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | 1 on a hit, 0 on a miss |
| rsp_handle | output | P_W | Handle found or allocated |
| hit_evt | output | 1 | Hit event pulse |
| miss_evt | output | 1 | Miss event pulse |
| flush_evt | output | 1 | Full flush caused by a store shortage |

## Verification
Each response is due a fixed number of edges after the accepting edge: i+1 for a hit at slot i, i+2 for a miss that stops at empty slot i, and CHAIN_LEN+1 for a miss over a full chain. The bench counts edges from acceptance and samples on falling edges. It compares the measured count with the count its own chain model predicts for that request, and checks the response fields and the event pulses in that same cycle. A flush takes effect at the edge that samples it, so the bench checks the result of a flush through the misses and handles of the lookups that follow it.

// File: rtl/pca_pkg.sv
package pca_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_ALLOC  = 2'd2
  } pca_state_e;

  // Chain-select hash; the caller keeps only the low index bits.
  function automatic logic [31:0] pca_hash(input logic [31:0] k);
    return k ^ (k >> 2);
  endfunction

endpackage

// File: rtl/pca_slot_table.sv
module pca_slot_table #(
  parameter int KEY_W  = 12,
  parameter int NCHAIN = 4,
  parameter int LEN    = 3,
  parameter int H_W    = 5,
  localparam int CI_W  = (NCHAIN > 1) ? $clog2(NCHAIN) : 1,
  localparam int SI_W  = (LEN > 1) ? $clog2(LEN) : 1,
  localparam int NSLOT = NCHAIN * LEN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic             wr_en,
  input  logic [CI_W-1:0]  wr_chain,
  input  logic [SI_W-1:0]  wr_slot,
  input  logic [KEY_W-1:0] wr_key,
  input  logic [H_W-1:0]   wr_handle,
  input  logic [CI_W-1:0]  rd_chain,
  input  logic [SI_W-1:0]  rd_slot,
  output logic [KEY_W-1:0] rd_key,
  output logic [H_W-1:0]   rd_handle
);

  localparam logic [KEY_W-1:0] EMPTY = '1;

  logic [NSLOT*KEY_W-1:0] key_flat;
  logic [NSLOT*H_W-1:0]   hdl_flat;

  for (genvar c = 0; c < NCHAIN; c++) begin : g_chain
    for (genvar s = 0; s < LEN; s++) begin : g_slot
      logic             sel;
      logic             key_en;
      logic [KEY_W-1:0] key_d;
      logic [KEY_W-1:0] key_q;
      logic [H_W-1:0]   hdl_q;

      assign sel = wr_en && (wr_chain == CI_W'(c)) && (wr_slot == SI_W'(s));

      // A write to this slot wins over a clear issued in the same cycle.
      always_comb begin
        key_en = sel || clr_all;
        key_d  = sel ? wr_key : EMPTY;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      key_q <= EMPTY;
        else if (key_en) key_q <= key_d;
      end

      always_ff @(posedge clk) begin
        if (sel) hdl_q <= wr_handle;
      end

      assign key_flat[(c*LEN+s)*KEY_W +: KEY_W] = key_q;
      assign hdl_flat[(c*LEN+s)*H_W +: H_W]     = hdl_q;
    end
  end

  logic [31:0] rd_idx;
  always_comb begin
    rd_idx    = 32'(rd_chain) * 32'(LEN) + 32'(rd_slot);
    rd_key    = key_flat[rd_idx*KEY_W +: KEY_W];
    rd_handle = hdl_flat[rd_idx*H_W +: H_W];
  end

endmodule

// File: rtl/pca_alloc.sv
module pca_alloc #(
  parameter int STORE = 16,
  parameter int LEN   = 3,
  parameter int P_W   = 5,
  localparam int SI_W = (LEN > 1) ? $clog2(LEN) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_clr,
  input  logic            alloc_en,
  input  logic [P_W-1:0]  alloc_cnt,
  input  logic            evict_en,
  output logic [P_W-1:0]  free_ptr,
  output logic            short_o,
  output logic [SI_W-1:0] rot_o
);

  localparam logic [P_W:0]    STORE_V = (P_W+1)'(STORE);
  localparam logic [SI_W-1:0] ROT_MAX = SI_W'(LEN - 1);

  logic [P_W-1:0]  fp_q, fp_d;
  logic            fp_en;
  logic [SI_W-1:0] rot_q, rot_d;
  logic [P_W:0]    room;

  always_comb begin
    room    = STORE_V - {1'b0, fp_q};
    short_o = room < {1'b0, alloc_cnt};
    fp_en   = ext_clr || alloc_en;
    if (ext_clr)      fp_d = '0;
    else if (short_o) fp_d = alloc_cnt;
    else              fp_d = fp_q + alloc_cnt;
    rot_d = (rot_q == ROT_MAX) ? '0 : rot_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fp_q <= '0;
    else if (fp_en) fp_q <= fp_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rot_q <= '0;
    else if (evict_en) rot_q <= rot_d;
  end

  assign free_ptr = fp_q;
  assign rot_o    = rot_q;

endmodule

// File: rtl/pca_ctrl.sv
module pca_ctrl
  import pca_pkg::*;
#(
  parameter int KEY_W  = 12,
  parameter int NCHAIN = 4,
  parameter int LEN    = 3,
  parameter int P_W    = 5,
  localparam int CI_W  = (NCHAIN > 1) ? $clog2(NCHAIN) : 1,
  localparam int SI_W  = (LEN > 1) ? $clog2(LEN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [KEY_W-1:0] req_key,
  input  logic [P_W-1:0]   req_count,
  input  logic             flush_in,
  output logic             req_ready,
  input  logic [KEY_W-1:0] rd_key,
  input  logic [P_W-1:0]   rd_handle,
  output logic [CI_W-1:0]  rd_chain,
  output logic [SI_W-1:0]  rd_slot,
  output logic             wr_en,
  output logic [CI_W-1:0]  wr_chain,
  output logic [SI_W-1:0]  wr_slot,
  output logic [KEY_W-1:0] wr_key,
  output logic [P_W-1:0]   wr_handle,
  output logic             clr_all,
  input  logic [P_W-1:0]   free_ptr,
  input  logic             short_i,
  input  logic [SI_W-1:0]  rot_i,
  output logic             ext_clr,
  output logic             alloc_en,
  output logic [P_W-1:0]   alloc_cnt,
  output logic             evict_en,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [P_W-1:0]   rsp_handle,
  output logic             hit_evt,
  output logic             miss_evt,
  output logic             flush_evt
);

  localparam logic [KEY_W-1:0] EMPTY    = '1;
  localparam logic [SI_W-1:0]  LAST_IDX = SI_W'(LEN - 1);

  pca_state_e       st_q, st_d;
  logic [KEY_W-1:0] key_q;
  logic [P_W-1:0]   cnt_q;
  logic [CI_W-1:0]  chain_q, chain_d;
  logic [SI_W-1:0]  idx_q, idx_d, vic_q, vic_d;
  logic             load_en, idx_en, vic_en;
  logic             rv_d, rh_d, rsp_en, fe_d;
  logic [P_W-1:0]   rhd_d;
  logic             rv_q, rh_q, fe_q;
  logic [P_W-1:0]   rhd_q;

  always_comb begin
    st_d      = st_q;
    load_en   = 1'b0;
    idx_en    = 1'b0;
    idx_d     = idx_q;
    vic_en    = 1'b0;
    vic_d     = vic_q;
    chain_d   = CI_W'(pca_hash(32'(req_key)));
    ext_clr   = 1'b0;
    alloc_en  = 1'b0;
    evict_en  = 1'b0;
    wr_en     = 1'b0;
    rv_d      = 1'b0;
    rh_d      = 1'b0;
    rhd_d     = rhd_q;
    rsp_en    = 1'b0;
    fe_d      = 1'b0;
    req_ready = 1'b0;
    wr_handle = short_i ? '0 : free_ptr;
    unique case (st_q)
      ST_IDLE: begin
        req_ready = !flush_in;
        if (flush_in) begin
          ext_clr = 1'b1;
        end else if (req_valid) begin
          load_en = 1'b1;
          idx_en  = 1'b1;
          idx_d   = '0;
          st_d    = ST_SEARCH;
        end
      end
      ST_SEARCH: begin
        if (rd_key == EMPTY) begin
          vic_en = 1'b1;
          vic_d  = idx_q;
          st_d   = ST_ALLOC;
        end else if (rd_key == key_q) begin
          rv_d   = 1'b1;
          rh_d   = 1'b1;
          rhd_d  = rd_handle;
          rsp_en = 1'b1;
          st_d   = ST_IDLE;
        end else if (idx_q == LAST_IDX) begin
          vic_en   = 1'b1;
          vic_d    = rot_i;
          evict_en = 1'b1;
          st_d     = ST_ALLOC;
        end else begin
          idx_en = 1'b1;
          idx_d  = idx_q + 1'b1;
        end
      end
      ST_ALLOC: begin
        alloc_en = 1'b1;
        wr_en    = 1'b1;
        rv_d     = 1'b1;
        rhd_d    = wr_handle;
        rsp_en   = 1'b1;
        fe_d     = short_i;
        st_d     = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
    clr_all = ext_clr || (alloc_en && short_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      rv_q <= 1'b0;
      fe_q <= 1'b0;
    end else begin
      st_q <= st_d;
      rv_q <= rv_d;
      fe_q <= fe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q   <= '0;
      cnt_q   <= '0;
      chain_q <= '0;
    end else if (load_en) begin
      key_q   <= req_key;
      cnt_q   <= req_count;
      chain_q <= chain_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vic_q <= '0;
    else if (vic_en) vic_q <= vic_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rh_q  <= 1'b0;
      rhd_q <= '0;
    end else if (rsp_en) begin
      rh_q  <= rh_d;
      rhd_q <= rhd_d;
    end
  end

  assign rd_chain   = chain_q;
  assign rd_slot    = idx_q;
  assign wr_chain   = chain_q;
  assign wr_slot    = vic_q;
  assign wr_key     = key_q;
  assign alloc_cnt  = cnt_q;
  assign rsp_valid  = rv_q;
  assign rsp_hit    = rh_q;
  assign rsp_handle = rhd_q;
  assign hit_evt    = rv_q && rh_q;
  assign miss_evt   = rv_q && !rh_q;
  assign flush_evt  = fe_q;

endmodule

// File: rtl/pc_chain_alloc.sv
module pc_chain_alloc #(
  parameter int KEY_W  = 12,
  parameter int NCHAIN = 4,
  parameter int LEN    = 3,
  parameter int STORE  = 16,
  localparam int P_W   = $clog2(STORE + 1),
  localparam int CI_W  = (NCHAIN > 1) ? $clog2(NCHAIN) : 1,
  localparam int SI_W  = (LEN > 1) ? $clog2(LEN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [KEY_W-1:0] req_key,
  input  logic [P_W-1:0]   req_count,
  output logic             req_ready,
  input  logic             flush_in,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [P_W-1:0]   rsp_handle,
  output logic             hit_evt,
  output logic             miss_evt,
  output logic             flush_evt
);

  logic [KEY_W-1:0] rd_key, wr_key;
  logic [P_W-1:0]   rd_handle, wr_handle, free_ptr, alloc_cnt;
  logic [CI_W-1:0]  rd_chain, wr_chain;
  logic [SI_W-1:0]  rd_slot, wr_slot, rot;
  logic             wr_en, clr_all, ext_clr, alloc_en, evict_en, short_w;

  pca_ctrl #(.KEY_W(KEY_W), .NCHAIN(NCHAIN), .LEN(LEN), .P_W(P_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_key(req_key), .req_count(req_count),
    .flush_in(flush_in), .req_ready(req_ready),
    .rd_key(rd_key), .rd_handle(rd_handle), .rd_chain(rd_chain), .rd_slot(rd_slot),
    .wr_en(wr_en), .wr_chain(wr_chain), .wr_slot(wr_slot), .wr_key(wr_key),
    .wr_handle(wr_handle), .clr_all(clr_all),
    .free_ptr(free_ptr), .short_i(short_w), .rot_i(rot),
    .ext_clr(ext_clr), .alloc_en(alloc_en), .alloc_cnt(alloc_cnt), .evict_en(evict_en),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_handle(rsp_handle),
    .hit_evt(hit_evt), .miss_evt(miss_evt), .flush_evt(flush_evt)
  );

  pca_slot_table #(.KEY_W(KEY_W), .NCHAIN(NCHAIN), .LEN(LEN), .H_W(P_W)) u_tab (
    .clk(clk), .rst_n(rst_n), .clr_all(clr_all),
    .wr_en(wr_en), .wr_chain(wr_chain), .wr_slot(wr_slot),
    .wr_key(wr_key), .wr_handle(wr_handle),
    .rd_chain(rd_chain), .rd_slot(rd_slot),
    .rd_key(rd_key), .rd_handle(rd_handle)
  );

  pca_alloc #(.STORE(STORE), .LEN(LEN), .P_W(P_W)) u_alloc (
    .clk(clk), .rst_n(rst_n), .ext_clr(ext_clr),
    .alloc_en(alloc_en), .alloc_cnt(alloc_cnt), .evict_en(evict_en),
    .free_ptr(free_ptr), .short_o(short_w), .rot_o(rot)
  );

endmodule

// File: rtl/pca_checker.sv
module pca_checker #(
  parameter int STORE = 16,
  parameter int P_W   = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic           flush_in,
  input logic           rsp_valid,
  input logic [P_W-1:0] rsp_handle,
  input logic           hit_evt,
  input logic           miss_evt,
  input logic           flush_evt
);

  p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_ready_at_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready || flush_in);

  p_flush_is_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_evt |-> miss_evt && (rsp_handle == '0));

  p_hit_handle_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |-> (32'(rsp_handle) <= STORE));

  p_ext_flush_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_in && !rsp_valid && $past(!rsp_valid) && !req_ready) |=> !rsp_valid);

endmodule

bind pc_chain_alloc pca_checker #(.STORE(STORE), .P_W(P_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .flush_in(flush_in), .rsp_valid(rsp_valid), .rsp_handle(rsp_handle),
  .hit_evt(hit_evt), .miss_evt(miss_evt), .flush_evt(flush_evt)
);

// File: tb/sim_pc_chain_alloc.sv
`timescale 1ns/1ps
module sim_pc_chain_alloc;

  localparam int KEY_W = 12, NCH = 4, LEN = 3, STORE = 16, P_W = 5;
  localparam int EMPTY = 4095;

  logic clk, rst_n, req_valid, flush_in;
  logic [KEY_W-1:0] req_key;
  logic [P_W-1:0] req_count;
  logic req_ready, rsp_valid, rsp_hit, hit_evt, miss_evt, flush_evt;
  logic [P_W-1:0] rsp_handle;

  int checks = 0, errors = 0;
  bit done = 0;
  int mk [NCH][LEN];
  int mh [NCH][LEN];
  int mfp, mrot;

  pc_chain_alloc #(.KEY_W(KEY_W), .NCHAIN(NCH), .LEN(LEN), .STORE(STORE)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_key(req_key),
    .req_count(req_count), .req_ready(req_ready), .flush_in(flush_in),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_handle(rsp_handle),
    .hit_evt(hit_evt), .miss_evt(miss_evt), .flush_evt(flush_evt));

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int c = 0; c < NCH; c++)
      for (int s = 0; s < LEN; s++) mk[c][s] = EMPTY;
    mfp = 0;
  endtask

  task automatic lookup(input int k, input int cnt);
    int ch, pos, lat, eh, eflush, vic, n;
    bit hit, empty_found;
    ch = (k ^ (k >> 2)) & (NCH - 1);
    hit = 0; empty_found = 0; pos = LEN; eh = 0; eflush = 0;
    for (int s = 0; s < LEN; s++) begin
      if (mk[ch][s] == EMPTY) begin empty_found = 1; pos = s; break; end
      if (mk[ch][s] == k) begin hit = 1; pos = s; break; end
    end
    if (hit) begin
      lat = pos + 1; eh = mh[ch][pos];
    end else begin
      if (empty_found) begin lat = pos + 2; vic = pos; end
      else begin lat = LEN + 1; vic = mrot; mrot = (mrot + 1) % LEN; end
      if (STORE - mfp < cnt) begin model_clear(); eflush = 1; end
      mk[ch][vic] = k; mh[ch][vic] = mfp; eh = mfp; mfp += cnt;
    end
    @(negedge clk);
    req_valid = 1; req_key = KEY_W'(k); req_count = P_W'(cnt);
    @(posedge clk); #1 req_valid = 0;
    n = 0;
    @(negedge clk);
    chk(req_ready == 0, "R10 busy after accept", int'(req_ready), 0);
    while (!rsp_valid && n < 20) begin
      @(posedge clk); n++; @(negedge clk);
    end
    chk(n == lat, "R3 response latency", n, lat);
    chk(rsp_hit == hit, "R2/R4 hit flag", int'(rsp_hit), int'(hit));
    chk(int'(rsp_handle) == eh, hit ? "R4 hit handle" : "R5/R7 miss handle", int'(rsp_handle), eh);
    chk(hit_evt == hit && miss_evt == !hit, "R5 event pulses", int'({hit_evt, miss_evt}), int'({hit, !hit}));
    chk(flush_evt == eflush, "R8 flush event", int'(flush_evt), eflush);
    @(posedge clk); @(negedge clk);
    chk(!rsp_valid && !hit_evt && !miss_evt && !flush_evt, "R10 single pulse", int'(rsp_valid), 0);
  endtask

  task automatic ext_flush();
    @(negedge clk); flush_in = 1;
    @(posedge clk); #1 flush_in = 0;
    model_clear();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; flush_in = 0; req_key = '0; req_count = '0;
    model_clear(); mrot = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1 && rsp_valid == 0, "R1 reset ready/valid", int'({req_ready, rsp_valid}), 2);
    chk(!hit_evt && !miss_evt && !flush_evt, "R1 reset events", int'({hit_evt, miss_evt, flush_evt}), 0);
    // R1: empty table, pointer 0 -> first lookup misses at slot 0 with handle 0
    lookup(5, 2);
    // R6: four keys on chain 0 force rotating evictions
    lookup(0, 1); lookup(64, 1); lookup(128, 1); lookup(192, 1); lookup(0, 1);
    // R7: zero-count allocation
    lookup(300, 0); lookup(300, 3);
    // R8: request larger than remaining room
    lookup(401, 16); lookup(402, 1); lookup(401, 1);
    // near-exhaustive sweep over keys and counts
    for (int i = 0; i < 300; i++) begin
      if (i == 150) ext_flush();   // R9
      lookup((i * 13 + i / 7) % 24, (i * 3) % 5);
    end
    // R9: flush wins over a same-cycle request
    @(negedge clk); flush_in = 1; req_valid = 1; req_key = 12'd7; req_count = 5'd1;
    #0.5 chk(req_ready == 0, "R9 flush priority", int'(req_ready), 0);
    @(posedge clk); #1 flush_in = 0; req_valid = 0;
    model_clear();
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      chk(rsp_valid == 0, "R9 no response to flush", int'(rsp_valid), 0);
    end
    lookup(7, 1); lookup(7, 1);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule